// File: doc/BRIEF.md
# Burst PSRAM Host Controller

This block sits between an on-chip requester and a 1M x 16 pseudo-static RAM that uses a clocked burst interface. A requester hands over one request at a time. The request carries a word address, a burst length, and the read or write direction. The controller turns it into a device access. It pulses the chip select and the address-valid strobe to start the access, counts the configured initial latency, and then moves one 16-bit word per clock. It pauses on any clock in which the device's WAIT output is asserted. WAIT can be programmed as active-high or active-low.

Read words come back with a one-cycle valid strobe. Write words are pulled from the requester with a per-word ready strobe, together with two byte-lane enables. The device refreshes itself, so its chip select may only stay low for a bounded number of cycles. When a burst would exceed that limit, the controller closes it and waits out the minimum chip-select high time. It then opens a new access at the next word address. The requester sees none of this except extra cycles. The device clock is enabled only while chip select is low, so the clock is held still whenever no burst is running.

Top module: `psram_burst_ctrl`

## Requirements
- R1: In the first cycle after reset, `mem_ce_n` and `mem_adv_n` are high, `mem_clk_en` is low, `req_ready` is high, and `rd_valid` and `wr_ready` are low.
- R2: One cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), the following holds:
  - `mem_ce_n` and `mem_adv_n` are low.
  - `mem_addr` equals `req_addr`.
  - `mem_we_n` is the inverse of `req_write`.
  - `mem_adv_n` stays low for exactly one cycle.
- R3: The first data cycle of an access is L cycles after the cycle in which `mem_adv_n` is low. L is `cfg_latency`+1 for codes 2 to 7, and 3 for codes 0 and 1. With WAIT never asserted, the first read word appears on `rd_valid` L+1 cycles after that cycle.
- R4: When `cfg_wait_low`=1, WAIT is asserted while `mem_wait` is low; when it is 0, WAIT is asserted while `mem_wait` is high. No word moves during a data cycle in which WAIT is asserted, and `wr_ready` is never high in such a cycle.
- R5: Each read word sampled from `mem_dq_in` is presented on `rd_data` with `rd_valid` high in the following cycle. Words arrive in ascending address order, wrapping modulo 2^20.
- R6: In every write data cycle without WAIT, the following holds:
  - `mem_dq_oe` is high.
  - `mem_dq_out` equals `wr_data`.
  - `mem_be_n` is the inverse of `wr_be`, where bit 0 is the lower byte and bit 1 the upper byte.
  - `wr_ready` is high, so the next word is taken.
- R7: `mem_ce_n` is never low for more than `CE_MAX_CYC` consecutive cycles. A burst that reaches this limit is closed.
- R8: A closed burst with words left restarts by itself. The restart is a new low cycle of `mem_ce_n` and `mem_adv_n` at an address equal to the request address plus the words already moved (modulo 2^20), in the same direction.
- R9: `mem_ce_n` stays high for at least `CE_HIGH_MIN` cycles between two accesses. `req_ready` is low while an access, a pending restart or that recovery is in progress.
- R10: `mem_clk_en` is high only while `mem_ce_n` is low.
- R11: A request moves exactly `req_len`+1 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | First word address |
| req_len | input | LEN_W | Number of words minus one |
| wr_data | input | DATA_W | Write word offered by requester |
| wr_be | input | DATA_W/8 | Byte-lane enables for the write word, bit 0 = lower byte |
| wr_ready | output | 1 | Write word taken this cycle |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | Read word valid |
| cfg_latency | input | 3 | Initial latency code |
| cfg_wait_low | input | 1 | 1 = WAIT is active-low |
| mem_clk_en | output | 1 | Device clock enable |
| mem_ce_n | output | 1 | Device chip select, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DATA_W/8 | Byte-lane selects, active low |
| mem_addr | output | ADDR_W | Device word address |
| mem_dq_out | output | DATA_W | Data driven to device |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Data from device |
| mem_wait | input | 1 | Device WAIT output |

## Verification
The bench pairs the controller with a behavioural device model. The model captures the address, counts latency and inserts random WAIT stalls under either polarity. It returns a poison word outside valid data slots, so sampling one cycle early or late shows up as a data mismatch.

The directed cases cover the following:
- single-word bursts, and bursts at the shortest and longest latency codes with no stalls, which isolate exact latency;
- a burst that crosses the top of the address space, which checks the wrap;
- a 256-word read that is split many times, which separates restart addressing from plain counting.

Constrained random mixes of reads and writes over a small address window, with random byte enables, then tell lane masking and write-then-read ordering apart from the per-word strobes.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } psc_state_e;

  // Clocks from the address cycle to the first data cycle.
  function automatic logic [3:0] lat_cycles(input logic [2:0] code);
    if (code < 3'd2) return 4'd3;
    return {1'b0, code} + 4'd1;
  endfunction

endpackage

// File: rtl/psc_ce_guard.sv
// Tracks how long chip select has been low and how long it has been high.
module psc_ce_guard #(
  parameter int CE_MAX_CYC  = 32,
  parameter int CE_HIGH_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  output logic low_last,
  output logic high_ok
);
  localparam int LOW_W = $clog2(CE_MAX_CYC + 1);
  localparam int HI_W  = $clog2(CE_HIGH_MIN + 1);
  localparam logic [LOW_W-1:0] LOW_TOP = LOW_W'(CE_MAX_CYC - 1);
  localparam logic [HI_W-1:0]  HI_TOP  = HI_W'(CE_HIGH_MIN - 1);

  logic [LOW_W-1:0] low_cnt;
  logic [HI_W-1:0]  hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      hi_cnt  <= HI_TOP;
    end else if (ce_n) begin
      low_cnt <= '0;
      if (hi_cnt != HI_TOP) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (low_cnt != LOW_TOP) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign low_last = ~ce_n & (low_cnt == LOW_TOP);
  assign high_ok  = ce_n & (hi_cnt == HI_TOP);
endmodule

// File: rtl/psc_rd_capture.sv
// Registers each read word taken from the device bus.
module psc_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      dvalid <= take;
      if (take) dout <= din;
    end
  end
endmodule

// File: rtl/psc_seq.sv
// Access sequencer: start, latency count, data phase, split and restart.
module psc_seq
  import psc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [2:0]          cfg_latency,
  input  logic                cfg_wait_low,
  input  logic                mem_wait,
  input  logic                low_last,
  input  logic                high_ok,
  output logic                req_ready,
  output logic                rd_take,
  output logic                wr_ready,
  output logic                mem_clk_en,
  output logic                mem_ce_n,
  output logic                mem_adv_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_dq_oe
);
  localparam int BE_W = DATA_W / 8;
  localparam int RM_W = LEN_W + 1;

  psc_state_e        state;
  logic              ce_n_q, adv_n_q, we_n_q, oe_n_q, clk_en_q;
  logic              kind_wr, pend;
  logic [ADDR_W-1:0] addr_q, next_addr;
  logic [RM_W-1:0]   remain;
  logic [3:0]        lat_cnt, lat_tgt;
  logic              wait_act, in_data, xfer, last_word, go_new, go_again;

  always_comb begin
    wait_act  = cfg_wait_low ? ~mem_wait : mem_wait;
    in_data   = (state == ST_DATA);
    xfer      = in_data & ~wait_act;
    last_word = xfer & (remain == RM_W'(1));
    req_ready = (state == ST_IDLE) & high_ok & ~pend;
    go_new    = req_valid & req_ready;
    go_again  = (state == ST_IDLE) & high_ok & pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ce_n_q    <= 1'b1;
      adv_n_q   <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      clk_en_q  <= 1'b0;
      kind_wr   <= 1'b0;
      pend      <= 1'b0;
      addr_q    <= '0;
      next_addr <= '0;
      remain    <= '0;
      lat_cnt   <= '0;
      lat_tgt   <= 4'd3;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (go_new | go_again) begin
            state    <= ST_LAT;
            ce_n_q   <= 1'b0;
            adv_n_q  <= 1'b0;
            clk_en_q <= 1'b1;
            lat_cnt  <= '0;
            lat_tgt  <= lat_cycles(cfg_latency);
            if (go_new) begin
              kind_wr   <= req_write;
              we_n_q    <= ~req_write;
              addr_q    <= req_addr;
              next_addr <= req_addr;
              remain    <= RM_W'(req_len) + RM_W'(1);
            end else begin
              we_n_q <= ~kind_wr;
              addr_q <= next_addr;
              pend   <= 1'b0;
            end
          end
        end
        ST_LAT: begin
          adv_n_q <= 1'b1;
          oe_n_q  <= kind_wr;
          lat_cnt <= lat_cnt + 4'd1;
          if (lat_cnt == lat_tgt - 4'd1) state <= ST_DATA;
        end
        ST_DATA: begin
          if (xfer) begin
            next_addr <= next_addr + 1'b1;
            remain    <= remain - 1'b1;
          end
          if (last_word | low_last) begin
            state    <= ST_IDLE;
            ce_n_q   <= 1'b1;
            clk_en_q <= 1'b0;
            we_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            pend     <= ~last_word;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_ce_n   = ce_n_q;
  assign mem_adv_n  = adv_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_clk_en = clk_en_q;
  assign mem_addr   = addr_q;
  assign mem_dq_oe  = in_data & kind_wr;
  assign mem_be_n   = kind_wr ? ~(wr_be & {BE_W{in_data}}) : {BE_W{ce_n_q}};
  assign rd_take    = xfer & ~kind_wr;
  assign wr_ready   = xfer & kind_wr;
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 8,
  parameter int CE_MAX_CYC  = 32,
  parameter int CE_HIGH_MIN = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  output logic                wr_ready,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  input  logic [2:0]          cfg_latency,
  input  logic                cfg_wait_low,
  output logic                mem_clk_en,
  output logic                mem_ce_n,
  output logic                mem_adv_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in,
  input  logic                mem_wait
);
  logic low_last, high_ok, rd_take;

  psc_ce_guard #(.CE_MAX_CYC(CE_MAX_CYC), .CE_HIGH_MIN(CE_HIGH_MIN)) u_guard (
    .clk(clk), .rst(rst), .ce_n(mem_ce_n), .low_last(low_last), .high_ok(high_ok)
  );

  psc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_be(wr_be),
    .cfg_latency(cfg_latency), .cfg_wait_low(cfg_wait_low), .mem_wait(mem_wait),
    .low_last(low_last), .high_ok(high_ok), .req_ready(req_ready),
    .rd_take(rd_take), .wr_ready(wr_ready), .mem_clk_en(mem_clk_en),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_oe(mem_dq_oe)
  );

  psc_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .take(rd_take), .din(mem_dq_in),
    .dout(rd_data), .dvalid(rd_valid)
  );

  assign mem_dq_out = wr_data;
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int CE_MAX_CYC  = 32,
  parameter int CE_HIGH_MIN = 3
) (
  input logic clk,
  input logic rst,
  input logic mem_ce_n,
  input logic mem_adv_n,
  input logic mem_clk_en,
  input logic mem_oe_n,
  input logic req_ready,
  input logic wr_ready,
  input logic rd_valid,
  input logic mem_wait,
  input logic cfg_wait_low
);
  localparam int LW = $clog2(CE_MAX_CYC + 1);
  localparam int HW = $clog2(CE_HIGH_MIN + 1);
  localparam logic [LW-1:0] LO_SAT = LW'(CE_MAX_CYC);
  localparam logic [HW-1:0] HI_SAT = HW'(CE_HIGH_MIN);

  logic [LW-1:0] lo_run;
  logic [HW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_run <= '0;
      hi_run <= HI_SAT;
    end else if (mem_ce_n) begin
      lo_run <= '0;
      if (hi_run != HI_SAT) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != LO_SAT) lo_run <= lo_run + 1'b1;
    end
  end

  AST_CE_LOW_LIMIT: assert property (@(posedge clk) disable iff (rst) !mem_ce_n |-> (lo_run < LO_SAT)); // R7
  AST_CE_HIGH_GAP: assert property (@(posedge clk) disable iff (rst) $fell(mem_ce_n) |-> (hi_run == HI_SAT)); // R9
  AST_ADV_PULSE: assert property (@(posedge clk) disable iff (rst) !mem_adv_n |=> mem_adv_n); // R2
  AST_ADV_AT_START: assert property (@(posedge clk) disable iff (rst) $fell(mem_ce_n) |-> !mem_adv_n); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst) req_ready |-> mem_ce_n); // R9
  AST_CLK_STATIC: assert property (@(posedge clk) disable iff (rst) mem_ce_n |-> !mem_clk_en); // R10
  AST_WR_NO_WAIT: assert property (@(posedge clk) disable iff (rst) wr_ready |-> (cfg_wait_low ? mem_wait : !mem_wait)); // R4
  AST_RD_AFTER_OE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(!mem_oe_n)); // R5
endmodule

bind psram_burst_ctrl psc_checker #(.CE_MAX_CYC(CE_MAX_CYC), .CE_HIGH_MIN(CE_HIGH_MIN)) u_chk (
  .clk(clk), .rst(rst), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
  .mem_clk_en(mem_clk_en), .mem_oe_n(mem_oe_n), .req_ready(req_ready),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .mem_wait(mem_wait),
  .cfg_wait_low(cfg_wait_low)
);

// File: tb/sim_psram_burst_ctrl.sv
`timescale 1ns/1ps
module sim_psram_burst_ctrl;
  localparam int AW = 20, DW = 16, LW = 8, BW = 2, CEMAX = 32, HIMIN = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [2:0]    cfg_latency = 3'd2;
  logic          cfg_wait_low = 1'b0;
  logic [DW-1:0] wr_data, rd_data, mem_dq_out, mem_dq_in;
  logic [BW-1:0] wr_be, mem_be_n;
  logic          wr_ready, req_ready, rd_valid;
  logic          mem_clk_en, mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_dq_oe, mem_wait;
  logic [AW-1:0] mem_addr;

  psram_burst_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .cfg_latency(cfg_latency),
    .cfg_wait_low(cfg_wait_low), .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n),
    .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [2:0] code);
    return (code < 3'd2) ? 3 : int'(code) + 1;
  endfunction

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 7) ^ 16'hA5C3;
  endfunction

  // Device storage and the expected image
  logic [DW-1:0] dev_mem [int];
  logic [DW-1:0] exp_mem [int];

  function automatic logic [DW-1:0] dev_rd(input int a);
    return dev_mem.exists(a) ? dev_mem[a] : init_word(a);
  endfunction
  function automatic logic [DW-1:0] exp_rd(input int a);
    return exp_mem.exists(a) ? exp_mem[a] : init_word(a);
  endfunction

  // Behavioural device model
  bit            m_act = 1'b0, m_wr = 1'b0, m_stall = 1'b0;
  int            m_cyc = 0, m_lat = 3, stall_pct = 0;
  logic [AW-1:0] m_ptr = '0;
  logic          stall_now, m_slot;

  assign m_slot    = m_act && (m_cyc >= m_lat) && !m_stall;
  assign stall_now = m_act && ((m_cyc < m_lat) || m_stall);
  assign mem_wait  = cfg_wait_low ? !stall_now : stall_now;
  assign mem_dq_in = (m_slot && !m_wr) ? dev_rd(int'(m_ptr)) : 16'hDEAD;

  always @(posedge clk) begin
    m_stall <= ($urandom_range(0, 99) < stall_pct);
    if (mem_ce_n) m_act <= 1'b0;
    else if (!mem_adv_n && mem_clk_en) begin
      m_act <= 1'b1; m_cyc <= 1; m_ptr <= mem_addr;
      m_wr <= !mem_we_n; m_lat <= exp_lat(cfg_latency);
    end else if (m_act) begin
      m_cyc <= m_cyc + 1;
      if (m_slot) m_ptr <= m_ptr + 1'b1;
    end
  end

  // Write data source
  logic [DW-1:0] wdat [256];
  logic [BW-1:0] wbe  [256];
  int wptr = 0;
  assign wr_data = wdat[wptr[7:0]];
  assign wr_be   = wbe[wptr[7:0]];
  always @(posedge clk) begin
    if (req_valid && req_ready) wptr <= 0;
    else if (wr_ready) wptr <= wptr + 1;
  end

  // Current operation
  logic [AW-1:0] op_base = '0;
  bit  op_wr = 1'b0;
  int  done_words = 0, op_len = 0, splits = 0;
  int  cyc_cnt = 0, fall_cyc = 0, hi_run = 100, lo_run = 0;
  bit  prev_ce_n = 1'b1, first_pending = 1'b0, first_seg = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc_cnt++;
      chk(mem_clk_en == !mem_ce_n, "R10 clock enable vs chip select", mem_clk_en, !mem_ce_n);
      if (!mem_ce_n && prev_ce_n) begin
        chk(hi_run >= HIMIN, "R9 chip select high gap", hi_run, HIMIN);
        chk(!mem_adv_n && mem_addr == AW'(int'(op_base) + done_words) && mem_we_n == !op_wr,
            first_seg ? "R2 burst start" : "R8 restart address",
            {mem_adv_n, mem_we_n, mem_addr}, {1'b0, !op_wr, AW'(int'(op_base) + done_words)});
        if (!first_seg) splits++;
        first_seg = 1'b0;
        fall_cyc = cyc_cnt;
        first_pending = !op_wr && (stall_pct == 0) && (done_words == 0);
        lo_run = 0;
      end
      if (mem_ce_n && !prev_ce_n)
        chk(lo_run <= CEMAX, "R7 chip select low time", lo_run, CEMAX);
      if (mem_ce_n) hi_run++; else begin hi_run = 0; lo_run++; end
      prev_ce_n = mem_ce_n;

      if (rd_valid) begin
        if (first_pending) begin
          chk(cyc_cnt - fall_cyc == exp_lat(cfg_latency) + 1, "R3 first read word timing",
              cyc_cnt - fall_cyc, exp_lat(cfg_latency) + 1);
          first_pending = 1'b0;
        end
        chk(!op_wr && rd_data == exp_rd(int'(AW'(int'(op_base) + done_words))),
            "R5 read word", rd_data, exp_rd(int'(AW'(int'(op_base) + done_words))));
        done_words++;
      end

      if (m_slot && m_wr && !mem_ce_n) begin
        chk(wr_ready && mem_dq_oe, "R3 write slot taken", {wr_ready, mem_dq_oe}, 2'b11);
        chk(mem_dq_out == wdat[wptr[7:0]] && mem_be_n == ~wbe[wptr[7:0]], "R6 write lanes",
            {mem_be_n, mem_dq_out}, {~wbe[wptr[7:0]], wdat[wptr[7:0]]});
        begin
          logic [DW-1:0] w;
          w = dev_rd(int'(m_ptr));
          for (int b = 0; b < BW; b++)
            if (!mem_be_n[b]) w[b*8 +: 8] = mem_dq_out[b*8 +: 8];
          dev_mem[int'(m_ptr)] = w;
        end
      end else if (wr_ready) begin
        chk(1'b0, "R4 write word outside a free data slot", wr_ready, 0);
      end
      if (wr_ready) done_words++;
    end
  end

  task automatic wait_ready();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (req_ready) return;
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input int len1,
                       input logic [2:0] lat, input bit wl);
    wait_ready();
    cfg_latency = lat;
    cfg_wait_low = wl;
    if (wr) begin
      for (int i = 0; i <= len1; i++) begin
        logic [DW-1:0] w;
        wdat[i] = DW'($urandom);
        wbe[i]  = BW'($urandom);
        w = exp_rd(int'(AW'(int'(a) + i)));
        for (int b = 0; b < BW; b++)
          if (wbe[i][b]) w[b*8 +: 8] = wdat[i][b*8 +: 8];
        exp_mem[int'(AW'(int'(a) + i))] = w;
      end
    end
    op_base = a; op_wr = wr; done_words = 0; op_len = len1 + 1; first_seg = 1'b1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = LW'(len1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done_words >= op_len && req_ready) break;
      @(negedge clk);
    end
    repeat (HIMIN + 2) @(negedge clk);
    chk(done_words == op_len, "R11 words per request", done_words, op_len);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1..): run did not complete, actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin wdat[i] = '0; wbe[i] = '0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_adv_n && !mem_clk_en && req_ready && !rd_valid && !wr_ready,
        "R1 reset state", {mem_ce_n, mem_adv_n, mem_clk_en, req_ready, rd_valid, wr_ready}, 6'b110100);

    // Directed: exact latency without stalls
    stall_pct = 0;
    do_op(1'b1, 20'h00010, 0, 3'd2, 1'b0);
    do_op(1'b0, 20'h00010, 0, 3'd2, 1'b0);
    do_op(1'b0, 20'h00020, 3, 3'd0, 1'b1);
    do_op(1'b0, 20'h00030, 5, 3'd7, 1'b0);
    // Wrap past the top address
    do_op(1'b1, 20'hFFFF8, 15, 3'd3, 1'b1);
    do_op(1'b0, 20'hFFFF8, 15, 3'd3, 1'b0);
    // Long read with stalls and active-low WAIT, splits expected (R7)
    stall_pct = 25;
    splits = 0;
    do_op(1'b1, 20'h40000, 255, 3'd4, 1'b1);
    do_op(1'b0, 20'h40000, 255, 3'd6, 1'b1);
    chk(splits > 0, "R7 long burst split", splits, 1);

    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      stall_pct = $urandom_range(0, 40);
      do_op(1'($urandom), AW'($urandom_range(256, 383)), $urandom_range(0, 47),
            3'($urandom), 1'($urandom));
    end
    // Final readback of the random window
    stall_pct = 10;
    do_op(1'b0, 20'h00100, 180, 3'd2, 1'b0);
    summary();
  end
endmodule